// File: doc/BRIEF.md
# DSP Operand Fetch Unit

This block gathers the source operands for one arithmetic instruction of a small audio DSP. When `start` is pulsed with the instruction word, the unit works out which operand slots the instruction consumes and how many operand words follow it in program memory. The slots are the two multiplier inputs, the two ALU inputs and the shift amount. The unit then walks those words from `pc_in` upward. Each word is decoded as a direct or indirect memory address, a signed immediate, a reference to one or two registers, or a reference to three registers. Every value the words name is read through a synchronous data-memory port.

The gathered values go into a small pool. The slots left enabled by the operand mask then take pool entries in a fixed priority order. The unit also reports the writeback address chosen by the operand words and the program counter just past the last word consumed. Registers become memory addresses through a selectable bit map, and the result is XORed with a base. Register map, base and mask are captured at `start`.

Top module: `dsp_opfetch`

## Requirements
- R1: Slot requests come from instruction fields. MUXA is bits 11:10 and MUXB is bits 9:8. For either field, value 1 requests ALU input 1 and value 2 requests ALU input 2. Value 3 requests multiplier input 1, and also multiplier input 2 when bit 12 is 1. A shift request is raised only when bits 3:0 equal 8.
- R2: The operand word count is instruction bits 14:13. When it is zero and any slot is requested, four operands are gathered. When it is zero and nothing is requested, no word is read, `done` pulses in the cycle after `start`, and `next_pc` equals `pc_in`.
- R3: A word whose bits 15:13 are 100 names a memory address in bits 9:0. Bit 10 marks it indirect, and bit 11 marks that address as the writeback address.
- R4: A word whose bits 15:14 are 11 carries a 13-bit signed immediate in bits 12:0. The immediate is sign-extended to 16 bits and shifted left by 3 when bit 13 is 1. Immediates never set the writeback address.
- R5: A word with bit 15 clear names three registers. The fields are R1 in bits 3:0, R2 in bits 8:5 and R3 in bits 13:10, each with its indirect flag in the bit directly above it (4, 9, 14). The values are pooled in the order R3, R2, R1, and R1's address becomes the writeback address.
- R6: A word whose bits 15:13 are 101 names one register, R1 in bits 3:0 with indirect bit 4. When bit 10 is set it also names R2 in bits 8:5 with indirect bit 9, and R2 is pooled before R1. Bit 11 flags R1 and bit 12 flags R2 as the writeback address.
- R7: A register number r maps to a 10-bit address. Address bits 2:0 are r[2:0], bit 9 is r[3] and bits 7:3 are zero. Bit 8 depends on the map: maps 0 to 3 use r[2], map 4 uses r[3], map 5 uses NOT r[3], map 6 uses r[2]&r[3] and map 7 uses r[2]|r[3]. The address is then XORed with the register base.
- R8: An indirect reference first reads memory at the computed address. The low 10 bits of that value become the address whose contents are the operand, and that address is also the writeback candidate.
- R9: Mask bits 4..0 cover multiplier 1, multiplier 2, ALU 1, ALU 2 and shift, and a set bit removes that request. The remaining requests take pool entries from entry 0 in that same priority order. Masked and unrequested operand outputs keep their previous values.
- R10: `done` is a one-cycle pulse raised only after every needed word has been consumed. At that point `next_pc` is the address just past the last word read. `wb_valid` tells whether any word set a writeback address, and the last flagged address wins. A `start` while `busy` is ignored. At most one memory read is issued per cycle.
- R11: After reset all operand outputs, `wb_valid`, `done`, `busy` and both read strobes are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin gathering for `instr` (ignored while busy) |
| instr | input | 16 | Arithmetic instruction word |
| pc_in | input | 10 | Address of the first operand word |
| op_mask | input | 5 | Request mask, bit 4 multiplier 1 down to bit 0 shift |
| reg_map | input | 3 | Register-to-address map selector |
| reg_base | input | 10 | Base XORed into register addresses |
| busy | output | 1 | A fetch is in progress |
| pm_rd | output | 1 | Program memory read strobe |
| pm_addr | output | 10 | Program memory read address |
| pm_data | input | 16 | Program memory data, valid the cycle after `pm_rd` |
| dm_rd | output | 1 | Data memory read strobe |
| dm_addr | output | 10 | Data memory read address |
| dm_data | input | 16 | Data memory data, valid the cycle after `dm_rd` |
| mult1 | output | 16 | Multiplier operand 1 |
| mult2 | output | 16 | Multiplier operand 2 |
| alu1 | output | 16 | ALU operand 1 |
| alu2 | output | 16 | ALU operand 2 |
| shift_op | output | 16 | Shift-amount operand |
| wb_valid | output | 1 | A writeback address was selected |
| wb_addr | output | 10 | Selected writeback address |
| next_pc | output | 10 | Program address after the last operand word |
| done | output | 1 | One-cycle completion pulse |

## Verification
A wrong pool count or slot index shows at the `done` pulse as operands that are shifted by one entry, a `next_pc` that is off by whole words, or a missing or extra completion pulse. A bad register map, base or indirect path puts a wrong value on an operand port and a wrong `wb_addr` at that same completion. A fault in masking shows as a held output that changed, or an enabled slot that picked up its neighbour's value. Every such fault appears at the first `done` after the offending instruction.

// File: rtl/opf_pkg.sv
package opf_pkg;
   localparam int WORD_W = 16;
   localparam int ADDR_W = 10;
   localparam int REG_W  = 4;
   localparam int NREQ   = 5;
   localparam int SLOTS  = 3;
   localparam int CNT_W  = 3;

   // request bit positions, highest takes pool entries first
   localparam int RQ_M1 = 4;
   localparam int RQ_M2 = 3;
   localparam int RQ_A1 = 2;
   localparam int RQ_A2 = 1;
   localparam int RQ_SH = 0;

   typedef enum logic [2:0] {
      ST_IDLE, ST_PMRD, ST_DEC, ST_SLOT, ST_PTR, ST_DATA, ST_DIST
   } opf_state_e;

   typedef struct packed {
      logic              imm;
      logic              ind;
      logic              wb;
      logic [WORD_W-1:0] val;
   } opf_slot_t;
endpackage

// File: rtl/opf_req_decode.sv
module opf_req_decode
   import opf_pkg::*;
(
   input  logic [1:0]       cnt,
   input  logic             m2sel,
   input  logic [1:0]       mux_a,
   input  logic [1:0]       mux_b,
   input  logic [3:0]       shf,
   output logic [NREQ-1:0]  req,
   output logic [CNT_W-1:0] need
);
   always_comb begin
      req         = '0;
      req[RQ_M1]  = (mux_a == 2'd3) || (mux_b == 2'd3);
      req[RQ_M2]  = req[RQ_M1] && m2sel;
      req[RQ_A1]  = (mux_a == 2'd1) || (mux_b == 2'd1);
      req[RQ_A2]  = (mux_a == 2'd2) || (mux_b == 2'd2);
      req[RQ_SH]  = (shf == 4'd8);
      if (cnt != 2'd0)
         need = CNT_W'(cnt);
      else if (|req)
         need = CNT_W'(4);
      else
         need = '0;
   end
endmodule

// File: rtl/opf_word_decode.sv
module opf_word_decode
   import opf_pkg::*;
(
   input  logic [WORD_W-1:0]          word,
   input  logic [2:0]                 rmap,
   input  logic [ADDR_W-1:0]          rbase,
   output opf_slot_t [SLOTS-1:0]      slots,
   output logic [1:0]                 nslots
);
   function automatic logic [ADDR_W-1:0] reg_addr(input logic [REG_W-1:0] r,
                                                  input logic [2:0] m,
                                                  input logic [ADDR_W-1:0] b);
      logic [ADDR_W-1:0] a;
      logic              hi;
      case (m)
         3'd4:    hi = r[3];
         3'd5:    hi = ~r[3];
         3'd6:    hi = r[2] & r[3];
         3'd7:    hi = r[2] | r[3];
         default: hi = r[2];
      endcase
      a      = '0;
      a[2:0] = r[2:0];
      a[8]   = hi;
      a[9]   = r[3];
      return a ^ b;
   endfunction

   function automatic opf_slot_t mem_slot(input logic [ADDR_W-1:0] a,
                                          input logic ind, input logic wb);
      opf_slot_t s;
      s.imm = 1'b0;
      s.ind = ind;
      s.wb  = wb;
      s.val = WORD_W'(a);
      return s;
   endfunction

   logic [WORD_W-1:0] imm_ext;
   assign imm_ext = {{(WORD_W-13){word[12]}}, word[12:0]} << (word[13] ? 3 : 0);

   always_comb begin
      slots  = '0;
      nslots = 2'd1;
      if (!word[15]) begin
         slots[0] = mem_slot(reg_addr(word[13:10], rmap, rbase), word[14], 1'b0);
         slots[1] = mem_slot(reg_addr(word[8:5],   rmap, rbase), word[9],  1'b0);
         slots[2] = mem_slot(reg_addr(word[3:0],   rmap, rbase), word[4],  1'b1);
         nslots   = 2'd3;
      end else if (word[14]) begin
         slots[0].imm = 1'b1;
         slots[0].val = imm_ext;
      end else if (word[13]) begin
         if (word[10]) begin
            slots[0] = mem_slot(reg_addr(word[8:5], rmap, rbase), word[9], word[12]);
            slots[1] = mem_slot(reg_addr(word[3:0], rmap, rbase), word[4], word[11]);
            nslots   = 2'd2;
         end else begin
            slots[0] = mem_slot(reg_addr(word[3:0], rmap, rbase), word[4], word[11]);
         end
      end else begin
         slots[0] = mem_slot(word[ADDR_W-1:0], word[10], word[11]);
      end
   end
endmodule

// File: rtl/opf_distribute.sv
module opf_distribute
   import opf_pkg::*;
#(
   parameter int POOL_DEPTH = 6
)(
   input  logic [POOL_DEPTH-1:0][WORD_W-1:0] pool,
   input  logic [NREQ-1:0]                   req,
   output logic [NREQ-1:0][WORD_W-1:0]       vals
);
   localparam int PTR_W = $clog2(POOL_DEPTH);

   always_comb begin
      logic [PTR_W-1:0] ptr;
      ptr = '0;
      for (int k = NREQ-1; k >= 0; k--) begin
         vals[k] = pool[ptr];
         if (req[k]) ptr = ptr + PTR_W'(1);
      end
   end
endmodule

// File: rtl/dsp_opfetch.sv
module dsp_opfetch
   import opf_pkg::*;
#(
   parameter int POOL_DEPTH = 6
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [15:0]       instr,
   input  logic [9:0]        pc_in,
   input  logic [4:0]        op_mask,
   input  logic [2:0]        reg_map,
   input  logic [9:0]        reg_base,
   output logic              busy,
   output logic              pm_rd,
   output logic [9:0]        pm_addr,
   input  logic [15:0]       pm_data,
   output logic              dm_rd,
   output logic [9:0]        dm_addr,
   input  logic [15:0]       dm_data,
   output logic [15:0]       mult1,
   output logic [15:0]       mult2,
   output logic [15:0]       alu1,
   output logic [15:0]       alu2,
   output logic [15:0]       shift_op,
   output logic              wb_valid,
   output logic [9:0]        wb_addr,
   output logic [9:0]        next_pc,
   output logic              done
);
   localparam int PCNT_W = $clog2(POOL_DEPTH + 1);

   generate
      if (POOL_DEPTH < 6) begin : g_pool_too_small
         $error("POOL_DEPTH must hold a full three-register word past four operands");
      end
      if (ADDR_W != 10 || WORD_W != 16) begin : g_format_width
         $error("operand word formats fix a 16-bit word and 10-bit address");
      end
   endgenerate

   opf_state_e                      state_q;
   logic [ADDR_W-1:0]               pc_q, eff_q, base_q;
   logic [2:0]                      map_q;
   logic [NREQ-1:0]                 req_q, req_w;
   logic [CNT_W-1:0]                need_q, need_w;
   opf_slot_t [SLOTS-1:0]           slots_q, slots_w;
   logic [1:0]                      nslots_q, nslots_w, sidx_q;
   logic [PCNT_W-1:0]               pcnt_q;
   logic [POOL_DEPTH-1:0][WORD_W-1:0] pool_q;
   logic [NREQ-1:0][WORD_W-1:0]     op_q, vals_w;
   opf_slot_t                       cur;
   logic                            push_en, last_slot, filled;
   logic [WORD_W-1:0]               push_val;
   logic                            unused_bits;

   assign unused_bits = ^{instr[15], instr[7:4]};

   opf_req_decode u_req (
      .cnt   (instr[14:13]),
      .m2sel (instr[12]),
      .mux_a (instr[11:10]),
      .mux_b (instr[9:8]),
      .shf   (instr[3:0]),
      .req   (req_w),
      .need  (need_w)
   );

   opf_word_decode u_word (
      .word   (pm_data),
      .rmap   (map_q),
      .rbase  (base_q),
      .slots  (slots_w),
      .nslots (nslots_w)
   );

   opf_distribute #(.POOL_DEPTH(POOL_DEPTH)) u_dist (
      .pool (pool_q),
      .req  (req_q),
      .vals (vals_w)
   );

   assign cur       = slots_q[sidx_q];
   assign last_slot = (sidx_q == nslots_q - 2'd1);
   assign push_en   = (state_q == ST_DATA) || (state_q == ST_SLOT && cur.imm);
   assign push_val  = (state_q == ST_DATA) ? dm_data : cur.val;
   assign filled    = ({1'b0, pcnt_q} + 1'b1) >= (PCNT_W+1)'(need_q);

   assign busy    = (state_q != ST_IDLE);
   assign pm_rd   = (state_q == ST_PMRD);
   assign pm_addr = pc_q;

   always_comb begin
      dm_rd   = 1'b0;
      dm_addr = cur.val[ADDR_W-1:0];
      if (state_q == ST_SLOT && !cur.imm) begin
         dm_rd = 1'b1;
      end else if (state_q == ST_PTR) begin
         dm_rd   = 1'b1;
         dm_addr = dm_data[ADDR_W-1:0];
      end
   end

   // pool entries, each written when the fill count points at it
   for (genvar i = 0; i < POOL_DEPTH; i++) begin : g_pool
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            pool_q[i] <= '0;
         else if (push_en && pcnt_q == PCNT_W'(i))
            pool_q[i] <= push_val;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         pc_q     <= '0;
         eff_q    <= '0;
         base_q   <= '0;
         map_q    <= '0;
         req_q    <= '0;
         need_q   <= '0;
         slots_q  <= '0;
         nslots_q <= '0;
         sidx_q   <= '0;
         pcnt_q   <= '0;
         op_q     <= '0;
         wb_valid <= 1'b0;
         wb_addr  <= '0;
         next_pc  <= '0;
         done     <= 1'b0;
      end else begin
         done <= 1'b0;
         if (push_en) pcnt_q <= pcnt_q + 1'b1;
         unique case (state_q)
            ST_IDLE: if (start) begin
               pc_q     <= pc_in;
               map_q    <= reg_map;
               base_q   <= reg_base;
               req_q    <= req_w & ~op_mask;
               need_q   <= need_w;
               pcnt_q   <= '0;
               wb_valid <= 1'b0;
               if (need_w == '0) begin
                  next_pc <= pc_in;
                  done    <= 1'b1;
               end else begin
                  state_q <= ST_PMRD;
               end
            end
            ST_PMRD: begin
               pc_q    <= pc_q + 1'b1;
               state_q <= ST_DEC;
            end
            ST_DEC: begin
               slots_q  <= slots_w;
               nslots_q <= nslots_w;
               sidx_q   <= '0;
               state_q  <= ST_SLOT;
            end
            ST_SLOT: begin
               eff_q <= cur.val[ADDR_W-1:0];
               if (!cur.imm)
                  state_q <= cur.ind ? ST_PTR : ST_DATA;
               else if (!last_slot) begin
                  sidx_q <= sidx_q + 1'b1;
               end else
                  state_q <= filled ? ST_DIST : ST_PMRD;
            end
            ST_PTR: begin
               eff_q   <= dm_data[ADDR_W-1:0];
               state_q <= ST_DATA;
            end
            ST_DATA: begin
               if (cur.wb) begin
                  wb_valid <= 1'b1;
                  wb_addr  <= eff_q;
               end
               if (!last_slot) begin
                  sidx_q  <= sidx_q + 1'b1;
                  state_q <= ST_SLOT;
               end else
                  state_q <= filled ? ST_DIST : ST_PMRD;
            end
            ST_DIST: begin
               for (int k = 0; k < NREQ; k++)
                  if (req_q[k]) op_q[k] <= vals_w[k];
               next_pc <= pc_q;
               done    <= 1'b1;
               state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign mult1    = op_q[RQ_M1];
   assign mult2    = op_q[RQ_M2];
   assign alu1     = op_q[RQ_A1];
   assign alu2     = op_q[RQ_A2];
   assign shift_op = op_q[RQ_SH];
endmodule

// File: rtl/opf_checker.sv
module opf_checker (
   input logic        clk,
   input logic        rst_n,
   input logic        start,
   input logic        busy,
   input logic        done,
   input logic [1:0]  cnt,
   input logic [3:0]  mux,
   input logic [3:0]  shf,
   input logic        pm_rd,
   input logic        dm_rd,
   input logic [4:0]  req_q,
   input logic [15:0] mult1,
   input logic [15:0] shift_op
);
   // R10
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R10
   one_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(pm_rd && dm_rd));

   // R2
   empty_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && cnt == 2'd0 && mux == 4'd0 && shf != 4'd8) |=> done);

   // R9
   masked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !req_q[4]) |-> $stable(mult1));

   // R9
   shift_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !req_q[0]) |-> $stable(shift_op));

   // R10
   quiet_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!pm_rd && !dm_rd && !busy));
endmodule

bind dsp_opfetch opf_checker u_opf_checker (
   .clk      (clk),
   .rst_n    (rst_n),
   .start    (start),
   .busy     (busy),
   .done     (done),
   .cnt      (instr[14:13]),
   .mux      (instr[11:8]),
   .shf      (instr[3:0]),
   .pm_rd    (pm_rd),
   .dm_rd    (dm_rd),
   .req_q    (req_q),
   .mult1    (mult1),
   .shift_op (shift_op)
);

// File: tb/test_dsp_opfetch.sv
`timescale 1ns/1ps
module test_dsp_opfetch;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [15:0] instr = '0;
   logic [9:0]  pc_in = '0;
   logic [4:0]  op_mask = '0;
   logic [2:0]  reg_map = '0;
   logic [9:0]  reg_base = '0;
   logic        busy, pm_rd, dm_rd, wb_valid, done;
   logic [9:0]  pm_addr, dm_addr, wb_addr, next_pc;
   logic [15:0] pm_data = '0, dm_data = '0;
   logic [15:0] mult1, mult2, alu1, alu2, shift_op;

   always #2 clk = ~clk;

   dsp_opfetch i_dsp_opfetch (
      .clk(clk), .rst_n(rst_n), .start(start), .instr(instr), .pc_in(pc_in),
      .op_mask(op_mask), .reg_map(reg_map), .reg_base(reg_base), .busy(busy),
      .pm_rd(pm_rd), .pm_addr(pm_addr), .pm_data(pm_data),
      .dm_rd(dm_rd), .dm_addr(dm_addr), .dm_data(dm_data),
      .mult1(mult1), .mult2(mult2), .alu1(alu1), .alu2(alu2), .shift_op(shift_op),
      .wb_valid(wb_valid), .wb_addr(wb_addr), .next_pc(next_pc), .done(done)
   );

   logic [15:0] pm_mem [1024];
   logic [15:0] dm_mem [1024];

   always @(posedge clk) begin
      if (pm_rd) pm_data <= pm_mem[pm_addr];
      if (dm_rd) dm_data <= dm_mem[dm_addr];
   end

   typedef struct {
      logic [4:0][15:0] ops;
      logic             wbv;
      logic [9:0]       wba;
      logic [9:0]       npc;
      string            tag;
   } exp_t;

   exp_t        sb_q[$];
   int          n_chk = 0, n_fail = 0, n_done = 0;
   logic [4:0][15:0] m_op = '0;
   logic [15:0] m_pool [8];
   int          m_cnt;
   logic        m_wbv;
   logic [9:0]  m_wba;
   bit          finished = 0;

   task automatic chk(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   function automatic logic [9:0] m_addr(input logic [3:0] r, input logic [2:0] mp, input logic [9:0] bs);
      logic b8;
      if (mp == 3'd4)      b8 = r[3];
      else if (mp == 3'd5) b8 = ~r[3];
      else if (mp == 3'd6) b8 = r[2] & r[3];
      else if (mp == 3'd7) b8 = r[2] | r[3];
      else                 b8 = r[2];
      return {r[3], b8, 5'b0, r[2:0]} ^ bs;
   endfunction

   task automatic take_mem(input logic [9:0] a0, input logic ind, input logic wb);
      logic [9:0] a;
      a = a0;
      if (ind) a = dm_mem[a][9:0];
      m_pool[m_cnt] = dm_mem[a];
      m_cnt++;
      if (wb) begin m_wbv = 1'b1; m_wba = a; end
   endtask

   // reference from the requirements
   task automatic model(input logic [15:0] ins, input logic [9:0] pc0, input logic [4:0] msk,
                        input logic [2:0] mp, input logic [9:0] bs, output exp_t e);
      logic [4:0] rq;
      int         need, p;
      logic [9:0] pc;
      logic [15:0] w;
      rq = '0;
      for (int f = 0; f < 2; f++) begin
         logic [1:0] mx;
         mx = (f == 0) ? ins[11:10] : ins[9:8];
         if (mx == 2'd3) begin rq[4] = 1'b1; if (ins[12]) rq[3] = 1'b1; end
         if (mx == 2'd1) rq[2] = 1'b1;
         if (mx == 2'd2) rq[1] = 1'b1;
      end
      if (ins[3:0] == 4'd8) rq[0] = 1'b1;
      need = int'(ins[14:13]);
      if (need == 0 && rq != 0) need = 4;
      pc = pc0; m_cnt = 0; m_wbv = 1'b0; m_wba = '0;
      while (m_cnt < need) begin
         w = pm_mem[pc];
         pc = pc + 10'd1;
         if (!w[15]) begin
            take_mem(m_addr(w[13:10], mp, bs), w[14], 1'b0);
            take_mem(m_addr(w[8:5], mp, bs), w[9], 1'b0);
            take_mem(m_addr(w[3:0], mp, bs), w[4], 1'b1);
         end else if (w[14]) begin
            logic [15:0] v;
            v = {{3{w[12]}}, w[12:0]};
            if (w[13]) v = v << 3;
            m_pool[m_cnt] = v;
            m_cnt++;
         end else if (w[13]) begin
            if (w[10]) take_mem(m_addr(w[8:5], mp, bs), w[9], w[12]);
            take_mem(m_addr(w[3:0], mp, bs), w[4], w[11]);
         end else begin
            take_mem(w[9:0], w[10], w[11]);
         end
      end
      rq = rq & ~msk;
      p = 0;
      for (int k = 4; k >= 0; k--)
         if (rq[k]) begin m_op[k] = m_pool[p]; p++; end
      e.ops = m_op;
      e.wbv = m_wbv;
      e.wba = m_wba;
      e.npc = pc;
   endtask

   // monitor: pops one expected item per completion pulse
   always @(negedge clk) begin
      if (rst_n && done && !finished) begin
         n_done++;
         if (sb_q.size() == 0) begin
            n_chk++; n_fail++;
            $display("FAIL R10 unexpected done: actual 1 expected 0");
         end else begin
            exp_t e;
            e = sb_q.pop_front();
            chk(e.tag, "mult1", mult1, e.ops[4]);
            chk(e.tag, "mult2", mult2, e.ops[3]);
            chk(e.tag, "alu1", alu1, e.ops[2]);
            chk(e.tag, "alu2", alu2, e.ops[1]);
            chk(e.tag, "shift_op", shift_op, e.ops[0]);
            chk(e.tag, "wb_valid", 16'(wb_valid), 16'(e.wbv));
            if (e.wbv) chk(e.tag, "wb_addr", 16'(wb_addr), 16'(e.wba));
            chk(e.tag, "next_pc", 16'(next_pc), 16'(e.npc));
         end
      end
   end

   // driver: predicts, queues, then starts the unit
   task automatic run(input logic [15:0] ins, input logic [9:0] pc0, input logic [4:0] msk,
                      input logic [2:0] mp, input logic [9:0] bs, input string tag, input bit dbl);
      exp_t e;
      model(ins, pc0, msk, mp, bs, e);
      e.tag = tag;
      sb_q.push_back(e);
      @(negedge clk);
      instr = ins; pc_in = pc0; op_mask = msk; reg_map = mp; reg_base = bs; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      if (dbl) begin
         @(negedge clk);
         instr = 16'h0000; pc_in = 10'h3F0; start = 1'b1;
         @(negedge clk);
         start = 1'b0;
      end
      while (sb_q.size() != 0) @(negedge clk);
      repeat (3) @(negedge clk);
   endtask

   task automatic finish_up;
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   int cyc = 0;
   always @(posedge clk) begin
      cyc++;
      if (cyc == 100000 && !finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         finish_up();
      end
   end

   initial begin
      int dones_before;
      for (int i = 0; i < 1024; i++) begin
         pm_mem[i] = '0;
         dm_mem[i] = 16'(i * 40503) ^ 16'h1234;
      end
      // T2 direct address with writeback flag
      pm_mem[10'h040] = 16'h8923;
      // T3 indirect address
      pm_mem[10'h050] = 16'h8455;
      // T4 two immediates, one justified and negative
      pm_mem[10'h060] = 16'hFFFD;
      pm_mem[10'h061] = 16'hC123;
      // T5 three-register word then immediate
      pm_mem[10'h070] = 16'h32AA;
      pm_mem[10'h071] = 16'hC007;
      // T6 two-register word then one-register word
      pm_mem[10'h080] = 16'hB479;
      pm_mem[10'h081] = 16'hA802;
      // T7 four immediates under a mask
      pm_mem[10'h090] = 16'hC001;
      pm_mem[10'h091] = 16'hC002;
      pm_mem[10'h092] = 16'hC003;
      pm_mem[10'h093] = 16'hC004;
      // T8 one register under map 4
      pm_mem[10'h0A0] = 16'hA00E;
      // T9 mixed decode
      pm_mem[10'h0B0] = 16'hC055;
      pm_mem[10'h0B1] = 16'hE010;
      // T10 indirect three-register under maps 0 and 7
      pm_mem[10'h0C0] = 16'h7FFF;
      // T11 start while busy
      pm_mem[10'h0D0] = 16'h8C10;

      repeat (3) @(negedge clk);
      // R11 reset state
      chk("R11", "done", 16'(done), 16'h0);
      chk("R11", "busy", 16'(busy), 16'h0);
      chk("R11", "reads", 16'({pm_rd, dm_rd}), 16'h0);
      chk("R11", "mult1", mult1, 16'h0);
      chk("R11", "wb_valid", 16'(wb_valid), 16'h0);
      rst_n = 1'b1;
      @(negedge clk);

      run(16'h0000, 10'h020, 5'h00, 3'd0, 10'h000, "R2", 0);   // no requests
      run(16'h2400, 10'h040, 5'h00, 3'd0, 10'h000, "R3", 0);   // ALU1 from address
      run(16'h2200, 10'h050, 5'h00, 3'd0, 10'h000, "R8", 0);   // ALU2 indirect
      run(16'h5C00, 10'h060, 5'h00, 3'd0, 10'h000, "R4", 0);   // MULT1/2 immediates
      run(16'h1D08, 10'h070, 5'h00, 3'd5, 10'h0C4, "R5", 0);   // count 0 -> four
      run(16'h6908, 10'h080, 5'h00, 3'd6, 10'h003, "R6", 0);   // two + one register
      run(16'h1D08, 10'h090, 5'h10, 3'd7, 10'h000, "R9", 0);   // MULT1 masked
      run(16'h2300, 10'h0A0, 5'h00, 3'd4, 10'h000, "R7", 0);   // M2SEL 0 -> MULT1 only
      run(16'h4E07, 10'h0B0, 5'h00, 3'd1, 10'h000, "R1", 0);   // shift field 7: no shift request
      run(16'h0F08, 10'h0C0, 5'h00, 3'd0, 10'h2A5, "R7", 0);
      run(16'h0F08, 10'h0C0, 5'h01, 3'd7, 10'h15A, "R9", 0);   // shift masked, holds
      dones_before = n_done;
      run(16'h2400, 10'h0D0, 5'h00, 3'd2, 10'h000, "R10", 1);  // second start ignored
      chk("R10", "done count", 16'(n_done - dones_before), 16'h1);
      chk("R10", "idle after", 16'(busy), 16'h0);
      finish_up();
   end
endmodule